// File: doc/BRIEF.md
# Selectable MMU Segment Translator

This block is the address translation front end of a 32-bit core. The MMU style is read from a two-bit field of the configuration word that is loaded at reset: no MMU, fixed mapping, or a TLB-backed style. Each request carries a virtual address, a user-mode flag and the error-level flag from the status word. The block sorts the address into the user segment (below 0x80000000), the two unmapped kernel windows (0x80000000 to 0xBFFFFFFF) and the two mapped kernel windows (0xC0000000 and above). It handles the direct translations itself. In the TLB style it hands mapped addresses to an external lookup port and passes that port's answer through.

The result appears one cycle after the request, strobed by `rsp_valid`. It carries a physical address, read and write permission, and a status. The block also holds the configuration word and applies its write mask. It reports how many TLB entries the selected style exposes. For TLB maintenance commands it decides whether the command is carried out or raised as a reserved instruction.

The control is a small state machine whose state is the MMU style. `ST` values are NONE (field 0), TLB (field 1), BAD (field 2) and FIXED (field 3). The only transition is taken at reset: while reset is low, the state is loaded from the MMU-type field of the boot configuration word. After that the state holds, because the field cannot be written.

Top module: `mmu_seg_xlate`

## Requirements
- R1: The MMU-type field is bits [8:7] of the configuration word. Values 0, 1 and 3 select no MMU, TLB and fixed mapping. Value 2 drives `mmu_cfg_err` high, and every response then has status unsupported, with paddr 0, no permissions and no lookup.
- R2: With no MMU, user-segment and kseg2/kseg3 addresses translate to themselves with read and write permitted and status match. Status encoding: 0 = match, 1 = no-match, 2 = unsupported.
- R3: With fixed mapping, user-segment addresses gain 0x40000000 (modulo 2^32) when `req_erl` is 0 and pass unchanged when `req_erl` is 1, with read and write permitted.
- R4: In every valid style, a kernel-mode address from 0x80000000 to 0xBFFFFFFF translates to the address with bits [31:29] cleared. The status is match, both permissions are set, and no lookup is raised.
- R5: With fixed mapping, addresses at 0xC0000000 and above translate to themselves with read and write permitted.
- R6: In the TLB style, user-segment and kseg2/kseg3 accesses raise `tlb_lk_valid` in the request cycle with `tlb_lk_vaddr` equal to the virtual address. On a hit the response takes the port's paddr and permissions with status match. On a miss it gives status no-match, paddr 0 and no permissions.
- R7: A user-mode access at or above 0x80000000 responds with status unsupported, paddr 0 and no permissions, and raises no lookup.
- R8: `tlb_entries` is 1 with no MMU, with fixed mapping, or with an invalid field. In the TLB style it is `tlb_size_m1` + 1.
- R9: A TLB maintenance command (`tlb_cmd_valid`) raises `tlb_cmd_go` in the TLB style and `tlb_cmd_ri` in every other style, in the same cycle. Neither is raised without a command.
- R10: A configuration write makes the word (old AND 0x81FFFFF8) OR (write data bit 0), visible the next cycle. The MMU style and `mmu_cfg_err` do not change.
- R11: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and the response fields belong to that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg0_boot | input | 32 | Configuration word loaded while reset is low |
| cfg0_wr_en | input | 1 | Configuration write strobe |
| cfg0_wr_data | input | 32 | Configuration write data |
| cfg0_q | output | 32 | Current configuration word |
| mmu_cfg_err | output | 1 | The MMU-type field holds the unsupported value |
| tlb_size_m1 | input | 6 | TLB entry count minus one |
| tlb_entries | output | 7 | Entry count of the selected style |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address |
| req_user | input | 1 | Request made in user mode |
| req_erl | input | 1 | Error-level flag from the status word |
| tlb_lk_valid | output | 1 | Lookup request to the TLB |
| tlb_lk_vaddr | output | 32 | Lookup address |
| tlb_lk_hit | input | 1 | Lookup hit (same cycle) |
| tlb_lk_paddr | input | 32 | Physical address from the lookup |
| tlb_lk_rd_ok | input | 1 | Read permitted by the lookup |
| tlb_lk_wr_ok | input | 1 | Write permitted by the lookup |
| tlb_cmd_valid | input | 1 | TLB maintenance command present |
| tlb_cmd_go | output | 1 | Command is carried out |
| tlb_cmd_ri | output | 1 | Command is a reserved instruction |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | 32 | Physical address |
| rsp_rd_ok | output | 1 | Read permitted |
| rsp_wr_ok | output | 1 | Write permitted |
| rsp_status | output | 2 | 0 match, 1 no-match, 2 unsupported |

## Verification
A style state that disagrees with the configuration field shows in the very first response after reset: user addresses come back offset, unoffset or sent to the lookup port in the wrong style, and `tlb_entries` and the command outputs change level in the same cycle. A lost or extra response register stage shows as `rsp_valid` and the result fields shifted by one cycle against the request. A write mask that lets the MMU-type field move shows in `cfg0_q` on the cycle after the write and, through the style state, in the next translation. Each style is therefore swept over every 256 MB address region, both privilege levels and both error-level settings.

// File: rtl/mmu_seg_pkg.sv
package mmu_seg_pkg;

    typedef enum logic [1:0] {
        ST_NONE  = 2'd0,
        ST_TLB   = 2'd1,
        ST_BAD   = 2'd2,
        ST_FIXED = 2'd3
    } map_style_e;

    typedef enum logic [1:0] {
        XS_MATCH   = 2'd0,
        XS_NOMATCH = 2'd1,
        XS_UNSUP   = 2'd2
    } xlat_stat_e;

    typedef struct packed {
        logic [31:0] paddr;
        logic        rd_ok;
        logic        wr_ok;
        xlat_stat_e  stat;
    } xlat_res_t;

endpackage

// File: rtl/mmu_cfg_ctl.sv
module mmu_cfg_ctl
    import mmu_seg_pkg::*;
#(
    parameter int          CFG_W     = 32,
    parameter int          MT_LSB    = 7,
    parameter logic [31:0] KEEP_MASK = 32'h81FF_FFF8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] boot_cfg,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] cfg_q,
    output map_style_e       style_q,
    output logic             cfg_err
);
    localparam logic [CFG_W-1:0] LOW_BIT = {{(CFG_W-1){1'b0}}, 1'b1};

    // state register: style is taken from the boot word during reset only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            style_q <= map_style_e'(boot_cfg[MT_LSB +: 2]);
        end else begin
            style_q <= style_q;
        end
    end

    // configuration word with write mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= boot_cfg;
        end else if (wr_en) begin
            cfg_q <= (cfg_q & KEEP_MASK[CFG_W-1:0]) | (wr_data & LOW_BIT);
        end
    end

    // outputs of the state machine
    always_comb begin
        unique case (style_q)
            ST_NONE, ST_TLB, ST_FIXED: cfg_err = 1'b0;
            ST_BAD:                    cfg_err = 1'b1;
        endcase
    end

    p_field_held_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_en) |=> (cfg_q[MT_LSB +: 2] == $past(cfg_q[MT_LSB +: 2])));

    p_style_tracks_field_r1 : assert property (@(posedge clk) disable iff (!rst_n)
        (style_q == map_style_e'(cfg_q[MT_LSB +: 2])));

endmodule

// File: rtl/mmu_seg_decode.sv
module mmu_seg_decode #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] vaddr,
    input  logic          user,
    output logic          is_unsup,
    output logic          is_direct,
    output logic          is_mapped,
    output logic [AW-1:0] direct_pa
);
    localparam int DROP = 3;

    logic kern_window;

    always_comb begin
        kern_window = (vaddr[AW-1 -: 2] == 2'b10);
        is_unsup    = user && vaddr[AW-1];
        is_direct   = !user && kern_window;
        is_mapped   = !is_unsup && !is_direct;
        direct_pa   = {{DROP{1'b0}}, vaddr[AW-DROP-1:0]};
    end

endmodule

// File: rtl/mmu_map_select.sv
module mmu_map_select
    import mmu_seg_pkg::*;
#(
    parameter int          AW         = 32,
    parameter logic [31:0] FIX_OFFSET = 32'h4000_0000
) (
    input  map_style_e    style,
    input  logic          req_valid,
    input  logic [AW-1:0] vaddr,
    input  logic          erl,
    input  logic          is_unsup,
    input  logic          is_direct,
    input  logic          is_mapped,
    input  logic [AW-1:0] direct_pa,
    input  logic          lk_hit,
    input  logic [AW-1:0] lk_paddr,
    input  logic          lk_rd_ok,
    input  logic          lk_wr_ok,
    output logic          lk_valid,
    output xlat_res_t     res
);
    xlat_res_t granted;

    always_comb begin
        granted       = '0;
        granted.rd_ok = 1'b1;
        granted.wr_ok = 1'b1;
        granted.stat  = XS_MATCH;
        res           = '0;
        res.stat      = XS_UNSUP;
        lk_valid      = 1'b0;
        unique case (style)
            ST_BAD: begin
                res.stat = XS_UNSUP;
            end
            ST_NONE: begin
                if (is_direct) begin
                    res = granted; res.paddr = direct_pa;
                end else if (is_mapped) begin
                    res = granted; res.paddr = vaddr;
                end
            end
            ST_FIXED: begin
                if (is_direct) begin
                    res = granted; res.paddr = direct_pa;
                end else if (is_mapped) begin
                    res = granted;
                    if (!vaddr[AW-1] && !erl) res.paddr = vaddr + FIX_OFFSET[AW-1:0];
                    else                      res.paddr = vaddr;
                end
            end
            ST_TLB: begin
                if (is_direct) begin
                    res = granted; res.paddr = direct_pa;
                end else if (is_mapped) begin
                    lk_valid = req_valid;
                    if (lk_hit) begin
                        res.paddr = lk_paddr;
                        res.rd_ok = lk_rd_ok;
                        res.wr_ok = lk_wr_ok;
                        res.stat  = XS_MATCH;
                    end else begin
                        res.stat  = XS_NOMATCH;
                    end
                end
            end
        endcase
        if (is_unsup) begin
            res      = '0;
            res.stat = XS_UNSUP;
            lk_valid = 1'b0;
        end
    end

endmodule

// File: rtl/mmu_seg_xlate.sv
module mmu_seg_xlate
    import mmu_seg_pkg::*;
#(
    parameter int AW      = 32,
    parameter int CFG_W   = 32,
    parameter int MT_LSB  = 7,
    parameter int ENT_W   = 6,
    localparam int CNT_W  = ENT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg0_boot,
    input  logic             cfg0_wr_en,
    input  logic [CFG_W-1:0] cfg0_wr_data,
    output logic [CFG_W-1:0] cfg0_q,
    output logic             mmu_cfg_err,
    input  logic [ENT_W-1:0] tlb_size_m1,
    output logic [CNT_W-1:0] tlb_entries,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_vaddr,
    input  logic             req_user,
    input  logic             req_erl,
    output logic             tlb_lk_valid,
    output logic [AW-1:0]    tlb_lk_vaddr,
    input  logic             tlb_lk_hit,
    input  logic [AW-1:0]    tlb_lk_paddr,
    input  logic             tlb_lk_rd_ok,
    input  logic             tlb_lk_wr_ok,
    input  logic             tlb_cmd_valid,
    output logic             tlb_cmd_go,
    output logic             tlb_cmd_ri,
    output logic             rsp_valid,
    output logic [AW-1:0]    rsp_paddr,
    output logic             rsp_rd_ok,
    output logic             rsp_wr_ok,
    output logic [1:0]       rsp_status
);
    map_style_e    style;
    logic          is_unsup, is_direct, is_mapped;
    logic [AW-1:0] direct_pa;
    xlat_res_t     res;

    mmu_cfg_ctl #(.CFG_W(CFG_W), .MT_LSB(MT_LSB)) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .boot_cfg (cfg0_boot),
        .wr_en    (cfg0_wr_en),
        .wr_data  (cfg0_wr_data),
        .cfg_q    (cfg0_q),
        .style_q  (style),
        .cfg_err  (mmu_cfg_err)
    );

    mmu_seg_decode #(.AW(AW)) dec_i (
        .vaddr     (req_vaddr),
        .user      (req_user),
        .is_unsup  (is_unsup),
        .is_direct (is_direct),
        .is_mapped (is_mapped),
        .direct_pa (direct_pa)
    );

    mmu_map_select #(.AW(AW)) map_i (
        .style     (style),
        .req_valid (req_valid),
        .vaddr     (req_vaddr),
        .erl       (req_erl),
        .is_unsup  (is_unsup),
        .is_direct (is_direct),
        .is_mapped (is_mapped),
        .direct_pa (direct_pa),
        .lk_hit    (tlb_lk_hit),
        .lk_paddr  (tlb_lk_paddr),
        .lk_rd_ok  (tlb_lk_rd_ok),
        .lk_wr_ok  (tlb_lk_wr_ok),
        .lk_valid  (tlb_lk_valid),
        .res       (res)
    );

    assign tlb_lk_vaddr = req_vaddr;

    // style-dependent command handling and entry count
    always_comb begin
        unique case (style)
            ST_TLB: begin
                tlb_entries = {1'b0, tlb_size_m1} + CNT_W'(1);
                tlb_cmd_go  = tlb_cmd_valid;
                tlb_cmd_ri  = 1'b0;
            end
            ST_NONE, ST_FIXED, ST_BAD: begin
                tlb_entries = CNT_W'(1);
                tlb_cmd_go  = 1'b0;
                tlb_cmd_ri  = tlb_cmd_valid;
            end
        endcase
    end

    // response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_paddr  <= '0;
            rsp_rd_ok  <= 1'b0;
            rsp_wr_ok  <= 1'b0;
            rsp_status <= 2'd0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_paddr  <= res.paddr;
                rsp_rd_ok  <= res.rd_ok;
                rsp_wr_ok  <= res.wr_ok;
                rsp_status <= res.stat;
            end
        end
    end

    p_rsp_follows_req_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && req_valid) |=> rsp_valid);

    p_no_user_kernel_lookup_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        tlb_lk_valid |-> !(req_user && req_vaddr[AW-1]));

    p_user_kernel_unsup_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && req_valid && req_user && req_vaddr[AW-1]) |=> (rsp_status == 2'd2));

    p_window_direct_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && req_valid && !req_user && req_vaddr[AW-1 -: 2] == 2'b10 && !mmu_cfg_err)
        |=> (rsp_status == 2'd0 && rsp_paddr[AW-1 -: 3] == 3'b000));

    p_cmd_exclusive_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        tlb_cmd_valid |-> (tlb_cmd_go ^ tlb_cmd_ri));

    p_err_holds_r1 : assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mmu_cfg_err) |=> mmu_cfg_err);

endmodule

// File: tb/mmu_seg_xlate_tb.sv
`timescale 1ns/1ps
module mmu_seg_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cfg0_boot, cfg0_wr_data, cfg0_q;
    logic        cfg0_wr_en, mmu_cfg_err;
    logic [5:0]  tlb_size_m1;
    logic [6:0]  tlb_entries;
    logic        req_valid, req_user, req_erl;
    logic [31:0] req_vaddr;
    logic        tlb_lk_valid, tlb_lk_hit, tlb_lk_rd_ok, tlb_lk_wr_ok;
    logic [31:0] tlb_lk_vaddr, tlb_lk_paddr;
    logic        tlb_cmd_valid, tlb_cmd_go, tlb_cmd_ri;
    logic        rsp_valid, rsp_rd_ok, rsp_wr_ok;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_status;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    // bench TLB model: hit when bit 12 clear
    assign tlb_lk_hit   = ~tlb_lk_vaddr[12];
    assign tlb_lk_paddr = tlb_lk_vaddr ^ 32'h0F00_0000;
    assign tlb_lk_rd_ok = 1'b1;
    assign tlb_lk_wr_ok = tlb_lk_vaddr[13];

    mmu_seg_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .cfg0_boot(cfg0_boot), .cfg0_wr_en(cfg0_wr_en),
        .cfg0_wr_data(cfg0_wr_data), .cfg0_q(cfg0_q), .mmu_cfg_err(mmu_cfg_err),
        .tlb_size_m1(tlb_size_m1), .tlb_entries(tlb_entries), .req_valid(req_valid),
        .req_vaddr(req_vaddr), .req_user(req_user), .req_erl(req_erl),
        .tlb_lk_valid(tlb_lk_valid), .tlb_lk_vaddr(tlb_lk_vaddr), .tlb_lk_hit(tlb_lk_hit),
        .tlb_lk_paddr(tlb_lk_paddr), .tlb_lk_rd_ok(tlb_lk_rd_ok), .tlb_lk_wr_ok(tlb_lk_wr_ok),
        .tlb_cmd_valid(tlb_cmd_valid), .tlb_cmd_go(tlb_cmd_go), .tlb_cmd_ri(tlb_cmd_ri),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_rd_ok(rsp_rd_ok),
        .rsp_wr_ok(rsp_wr_ok), .rsp_status(rsp_status)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic reset_style(input int mt);
        @(negedge clk);
        rst_n = 1'b0;
        cfg0_boot = 32'hFE00_0C06 | (32'(mt) << 7);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one request; expected values derived from the requirements
    task automatic one_req(input int mt, input logic [31:0] va, input logic u, input logic e);
        logic [31:0] ep;
        logic        er, ew, elk;
        logic [1:0]  es;
        string       tag;
        ep = 32'h0; er = 1'b0; ew = 1'b0; es = 2'd2; elk = 1'b0; tag = "R1";
        if (mt == 2) begin
            tag = "R1";
        end else if (u && va[31]) begin
            tag = "R7";
        end else if (va[31:30] == 2'b10) begin
            tag = "R4"; ep = {3'b000, va[28:0]}; er = 1; ew = 1; es = 2'd0;
        end else if (mt == 0) begin
            tag = "R2"; ep = va; er = 1; ew = 1; es = 2'd0;
        end else if (mt == 3) begin
            tag = va[31] ? "R5" : "R3";
            ep = (!va[31] && !e) ? va + 32'h4000_0000 : va;
            er = 1; ew = 1; es = 2'd0;
        end else begin
            tag = "R6"; elk = 1'b1;
            if (!va[12]) begin
                ep = va ^ 32'h0F00_0000; er = 1; ew = va[13]; es = 2'd0;
            end else begin
                es = 2'd1;
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_user = u; req_erl = e;
        #1;
        chk({tag, " lookup strobe"}, {31'b0, tlb_lk_valid}, {31'b0, elk});
        if (elk) chk("R6 lookup addr", tlb_lk_vaddr, va);
        @(posedge clk);
        #1;
        chk("R11 rsp_valid", {31'b0, rsp_valid}, 32'd1);
        chk({tag, " paddr"}, rsp_paddr, ep);
        chk({tag, " perms"}, {30'b0, rsp_rd_ok, rsp_wr_ok}, {30'b0, er, ew});
        chk({tag, " status"}, {30'b0, rsp_status}, {30'b0, es});
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [27:0] lows [5];
        logic [31:0] exp_cfg;
        lows[0] = 28'h000_0000; lows[1] = 28'hFFF_FFFF; lows[2] = 28'h123_4000;
        lows[3] = 28'h567_3000; lows[4] = 28'h000_2000;
        rst_n = 1'b0; cfg0_boot = 32'h0; cfg0_wr_en = 1'b0; cfg0_wr_data = 32'h0;
        tlb_size_m1 = 6'd47; req_valid = 1'b0; req_vaddr = 32'h0; req_user = 1'b0;
        req_erl = 1'b0; tlb_cmd_valid = 1'b0;

        for (int mt = 0; mt < 4; mt++) begin
            reset_style(mt);
            #1;
            chk("R11 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
            chk("R1 cfg err", {31'b0, mmu_cfg_err}, {31'b0, mt == 2});
            tlb_size_m1 = 6'd47; #1;
            chk("R8 entries", {25'b0, tlb_entries}, (mt == 1) ? 32'd48 : 32'd1);
            tlb_size_m1 = 6'd63; #1;
            chk("R8 entries max", {25'b0, tlb_entries}, (mt == 1) ? 32'd64 : 32'd1);
            tlb_cmd_valid = 1'b1; #1;
            chk("R9 cmd go", {31'b0, tlb_cmd_go}, {31'b0, mt == 1});
            chk("R9 cmd ri", {31'b0, tlb_cmd_ri}, {31'b0, mt != 1});
            tlb_cmd_valid = 1'b0; #1;
            chk("R9 idle", {30'b0, tlb_cmd_go, tlb_cmd_ri}, 32'd0);

            for (int hi = 0; hi < 16; hi++)
                for (int li = 0; li < 5; li++)
                    for (int ue = 0; ue < 4; ue++)
                        one_req(mt, {4'(hi), lows[li]}, ue[1], ue[0]);

            @(negedge clk); req_valid = 1'b0;
            @(posedge clk); #1;
            chk("R11 no request", {31'b0, rsp_valid}, 32'd0);

            // configuration write masking
            @(negedge clk);
            exp_cfg = (cfg0_q & 32'h81FF_FFF8) | 32'h1;
            cfg0_wr_en = 1'b1; cfg0_wr_data = 32'hFFFF_FFFF;
            @(negedge clk);
            exp_cfg = (exp_cfg & 32'h81FF_FFF8);
            cfg0_wr_data = 32'h0000_0000;
            chk("R10 cfg write ones", cfg0_q, exp_cfg | 32'h1);
            @(negedge clk);
            cfg0_wr_en = 1'b0;
            chk("R10 cfg write zero", cfg0_q, exp_cfg);
            chk("R10 field held", {30'b0, cfg0_q[8:7]}, 32'(mt));
            chk("R10 err held", {31'b0, mmu_cfg_err}, {31'b0, mt == 2});
            one_req(mt, 32'h0000_1000, 1'b0, 1'b0);
            one_req(mt, 32'hC000_0000, 1'b0, 1'b0);
        end

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule